// File: doc/BRIEF.md
# Run-Time Programmable Two-Plane Logic Array

This block is a small logic array whose function is fixed at run time rather than at build time. It has a number of primary inputs, a set of product terms and a set of outputs. Each product term is an AND of any chosen literals. A literal is the true or complemented form of a primary input or of a registered output. Each output is an OR of any chosen product terms, so one product term can feed any number of outputs. A per-output polarity bit optionally inverts that sum. A per-output select bit then picks either this combinational value or a D flip-flop that captures it on every rising clock edge. Because the flip-flop values are also fed back into the AND plane, small state machines can be built in the array.

The configuration is written over a one-bit serial stream into a shadow shift register, one bit per cycle in which `cfg_valid` is high. The port never applies back-pressure, so it has no ready signal: every valid cycle accepts its bit. A single-cycle `cfg_commit` pulse copies the whole shadow register into the active configuration. The new function is in force from the next cycle on. A synchronous reset clears the shadow register, the active configuration and the output flip-flops, which leaves every output at 0.

With default parameters (4 inputs, 8 terms, 3 outputs), each term has 14 literal positions and the configuration is 142 bits long.

Top module: `pla_array`

## Requirements
- R1: While `rst` is high at a rising edge, the shadow register, the active configuration and the output flip-flops are cleared, so from the next cycle `out_data` is all zero.
- R2: Each rising edge with `cfg_valid` high shifts the shadow register one place toward index 0 and places `cfg_bit` at index CFG_W-1. After CFG_W accepted bits, the first bit sent sits at index 0. Edges with `cfg_valid` low leave the shadow register unchanged, whatever `cfg_bit` is.
- R3: The active configuration changes only at a rising edge with `cfg_commit` high. At that edge it takes the shadow value held before that edge, even if a bit is shifted in during the same cycle. Loading bits without a commit has no effect on `out_data`.
- R4: Signal j is primary input j for j < N_IN and flip-flop j-N_IN otherwise. In the AND plane, bit t*LIT_W+2j includes the true form of signal j in term t, and bit t*LIT_W+2j+1 includes its complement, with LIT_W = 2*(N_IN+N_OUT). A product term is 1 when all of its included literals are 1.
- R5: A product term with no included literal is 0.
- R6: Bit N_TERM*LIT_W + o*N_TERM + t joins term t into the sum of output o. One term may feed several outputs, and a term that is not joined does not contribute.
- R7: Bit N_TERM*LIT_W + N_OUT*N_TERM + o set to 1 inverts the sum of output o.
- R8: Each output flip-flop captures its polarity-adjusted sum at every rising edge. The select bit N_TERM*LIT_W + N_OUT*N_TERM + N_OUT + o set to 1 puts the flip-flop on `out_data[o]`. Set to 0, it puts the combinational value there.
- R9: The feedback literals always come from the flip-flops, whatever the select bits are.
- R10: At an edge that both commits a configuration and clocks the flip-flops, the flip-flops capture values formed under the configuration that was active before that edge.
- R11: A reset in the middle of sequential operation returns every flip-flop to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Accept `cfg_bit` at this edge |
| cfg_bit | input | 1 | Serial configuration data, index 0 first |
| cfg_commit | input | 1 | Copy the shadow register into the active configuration |
| in_data | input | N_IN | Primary inputs |
| out_data | output | N_OUT | Outputs after polarity and register select |

## Verification
Two events can fall in the same cycle: a configuration commit and the capture of the output flip-flops. A third can join them: a new serial bit arriving on the edge of the commit. The bench provokes this by running a feedback counter and committing a different configuration while it counts, with the commit cycle also carrying a valid bit. A cycle-accurate behavioural model predicts that the flip-flops capture under the old configuration and that the active image leaves out the bit shifted on the commit edge. The bench compares `out_data` with that model on every cycle.

// File: rtl/pla_pkg.sv
package pla_pkg;
  // Position of a literal inside the AND-plane image.
  function automatic int unsigned and_bit_idx(input int unsigned term, input int unsigned sig,
                                              input bit complement, input int unsigned lit_w);
    return term * lit_w + 2 * sig + (complement ? 1 : 0);
  endfunction

  // Position of an OR-plane link inside the image.
  function automatic int unsigned or_bit_idx(input int unsigned base, input int unsigned out_i,
                                             input int unsigned n_term, input int unsigned term);
    return base + out_i * n_term + term;
  endfunction
endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int unsigned CFG_W = 142
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic             cfg_bit,
  input  logic             cfg_commit,
  output logic [CFG_W-1:0] shadow_q,
  output logic [CFG_W-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (cfg_valid)
        shadow_q <= {cfg_bit, shadow_q[CFG_W-1:1]};
      if (cfg_commit)
        active_q <= shadow_q;
    end
  end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int unsigned N_SIG  = 7,
  parameter int unsigned N_TERM = 8,
  localparam int unsigned LIT_W = 2 * N_SIG,
  localparam int unsigned AND_W = N_TERM * LIT_W
) (
  input  logic [AND_W-1:0]  and_cfg,
  input  logic [N_SIG-1:0]  sig,
  output logic [N_TERM-1:0] term
);
  logic [LIT_W-1:0] lits;

  for (genvar j = 0; j < N_SIG; j++) begin : g_lit
    assign lits[2*j]   = sig[j];
    assign lits[2*j+1] = ~sig[j];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [LIT_W-1:0] row;
    assign row     = and_cfg[t*LIT_W +: LIT_W];
    // An empty row gives 0, so unused terms stay silent.
    assign term[t] = (|row) & (&(~row | lits));
  end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 3,
  localparam int unsigned OR_W = N_TERM * N_OUT
) (
  input  logic [OR_W-1:0]   or_cfg,
  input  logic [N_OUT-1:0]  pol_cfg,
  input  logic [N_TERM-1:0] term,
  output logic [N_OUT-1:0]  comb
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_sum
    assign comb[o] = (|(term & or_cfg[o*N_TERM +: N_TERM])) ^ pol_cfg[o];
  end
endmodule

// File: rtl/pla_out_regs.sv
module pla_out_regs #(
  parameter int unsigned N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_OUT-1:0] comb,
  input  logic [N_OUT-1:0] reg_sel,
  output logic [N_OUT-1:0] q,
  output logic [N_OUT-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= comb;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_sel
    assign out_data[o] = reg_sel[o] ? q[o] : comb[o];
  end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic             cfg_bit,
  input  logic             cfg_commit,
  input  logic [N_IN-1:0]  in_data,
  output logic [N_OUT-1:0] out_data
);
  import pla_pkg::*;

  localparam int unsigned N_SIG  = N_IN + N_OUT;
  localparam int unsigned LIT_W  = 2 * N_SIG;
  localparam int unsigned AND_W  = N_TERM * LIT_W;
  localparam int unsigned OR_W   = N_TERM * N_OUT;
  localparam int unsigned OR_B   = AND_W;
  localparam int unsigned POL_B  = OR_B + OR_W;
  localparam int unsigned SEL_B  = POL_B + N_OUT;
  localparam int unsigned CFG_W  = SEL_B + N_OUT;

  logic [CFG_W-1:0]  cfg_shadow;
  logic [CFG_W-1:0]  cfg_active;
  logic [N_SIG-1:0]  sig;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  comb;
  logic [N_OUT-1:0]  q;

  pla_cfg_store #(.CFG_W(CFG_W)) u_store (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .cfg_commit(cfg_commit), .shadow_q(cfg_shadow), .active_q(cfg_active)
  );

  assign sig = {q, in_data};

  pla_and_plane #(.N_SIG(N_SIG), .N_TERM(N_TERM)) u_and (
    .and_cfg(cfg_active[AND_W-1:0]), .sig(sig), .term(term)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .or_cfg(cfg_active[OR_B +: OR_W]), .pol_cfg(cfg_active[POL_B +: N_OUT]),
    .term(term), .comb(comb)
  );

  pla_out_regs #(.N_OUT(N_OUT)) u_regs (
    .clk(clk), .rst(rst), .comb(comb), .reg_sel(cfg_active[SEL_B +: N_OUT]),
    .q(q), .out_data(out_data)
  );
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned N_TERM = 8,
  parameter int unsigned N_OUT  = 3,
  localparam int unsigned LIT_W = 2 * (N_IN + N_OUT),
  localparam int unsigned CFG_W = N_TERM * LIT_W + N_TERM * N_OUT + 2 * N_OUT
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_valid,
  input logic             cfg_bit,
  input logic             cfg_commit,
  input logic [CFG_W-1:0] cfg_shadow,
  input logic [CFG_W-1:0] cfg_active,
  input logic [N_TERM-1:0] term,
  input logic [N_OUT-1:0] comb,
  input logic [N_OUT-1:0] q
);
  logic [N_TERM-1:0] row_used;
  for (genvar t = 0; t < N_TERM; t++) begin : g_used
    assign row_used[t] = |cfg_active[t*LIT_W +: LIT_W];
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0 && cfg_active == '0 && cfg_shadow == '0)); // R1
  AST_SHADOW_IDLE: assert property (@(posedge clk) disable iff (rst) !cfg_valid |=> $stable(cfg_shadow)); // R2
  AST_SHADOW_ENTRY: assert property (@(posedge clk) disable iff (rst) cfg_valid |=> cfg_shadow[CFG_W-1] == $past(cfg_bit)); // R2
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst) !cfg_commit |=> $stable(cfg_active)); // R3
  AST_ACTIVE_LOAD: assert property (@(posedge clk) disable iff (rst) cfg_commit |=> cfg_active == $past(cfg_shadow)); // R3
  AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (rst) (term & ~row_used) == '0); // R5
  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst) !rst |=> q == $past(comb)); // R8
endmodule

bind pla_array pla_array_chk #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit), .cfg_commit(cfg_commit),
  .cfg_shadow(cfg_shadow), .cfg_active(cfg_active), .term(term), .comb(comb), .q(q)
);

// File: tb/pla_array_test.sv
module pla_array_test;
  localparam int M = 4;
  localparam int P = 8;
  localparam int N = 3;
  localparam int LW = 2 * (M + N);
  localparam int ORB = P * LW;
  localparam int POLB = ORB + N * P;
  localparam int SELB = POLB + N;
  localparam int CW = SELB + N;

  logic clk = 0;
  logic rst = 1;
  logic cfg_valid = 0;
  logic cfg_bit = 0;
  logic cfg_commit = 0;
  logic [M-1:0] in_data = '0;
  logic [N-1:0] out_data;

  always #10 clk = ~clk;

  pla_array uut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_bit(cfg_bit),
    .cfg_commit(cfg_commit), .in_data(in_data), .out_data(out_data)
  );

  int checks = 0;
  int fails = 0;
  bit checking = 0;
  bit done = 0;
  string req = "R1";

  logic [CW-1:0] m_sh = '0;
  logic [CW-1:0] m_act = '0;
  logic [N-1:0] m_q = '0;
  logic [CW-1:0] img;

  function automatic logic [N-1:0] model_comb(input logic [CW-1:0] c, input logic [M-1:0] x,
                                              input logic [N-1:0] fq);
    logic [N-1:0] r;
    for (int o = 0; o < N; o++) begin
      bit acc = 0;
      for (int t = 0; t < P; t++) begin
        bit any = 0;
        bit prod = 1;
        for (int j = 0; j < M + N; j++) begin
          bit v = (j < M) ? x[j] : fq[j-M];
          if (c[t*LW+2*j])   begin any = 1; prod = prod & v;  end
          if (c[t*LW+2*j+1]) begin any = 1; prod = prod & !v; end
        end
        if (any && prod && c[ORB+o*P+t]) acc = 1;
      end
      r[o] = acc ^ c[POLB+o];
    end
    return r;
  endfunction

  function automatic logic [N-1:0] model_out();
    logic [N-1:0] cv = model_comb(m_act, in_data, m_q);
    logic [N-1:0] r;
    for (int o = 0; o < N; o++) r[o] = m_act[SELB+o] ? m_q[o] : cv[o];
    return r;
  endfunction

  always @(posedge clk) begin
    logic [CW-1:0] old_sh;
    if (rst) begin
      m_sh = '0; m_act = '0; m_q = '0;
    end else begin
      old_sh = m_sh;
      m_q = model_comb(m_act, in_data, m_q);
      if (cfg_valid) m_sh = {cfg_bit, m_sh[CW-1:1]};
      if (cfg_commit) m_act = old_sh;
    end
  end

  task automatic check(input string r, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: out_data=%b expected=%b at %0t", r, act, exp, $time);
    end
  endtask

  always begin
    @(negedge clk);
    #5;
    if (checking && !done) check(req, out_data, model_out());
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic set_lit(input int t, input int j, input bit neg);
    img[t*LW + 2*j + (neg ? 1 : 0)] = 1'b1;
  endtask

  task automatic set_or(input int o, input int t);
    img[ORB + o*P + t] = 1'b1;
  endtask

  // Shift img out, index 0 first; gap inserts idle cycles with junk data (R2).
  task automatic send_img(input bit gap, input bit commit_now);
    for (int k = 0; k < CW; k++) begin
      step(1);
      cfg_valid = 1; cfg_bit = img[k];
      if (gap && (k % 3 == 0)) begin
        step(1);
        cfg_valid = 0; cfg_bit = ~img[k];
      end
    end
    step(1);
    cfg_valid = 0; cfg_bit = 0;
    if (commit_now) begin
      cfg_commit = 1;
      step(1);
      cfg_commit = 0;
    end
  endtask

  task automatic sweep_inputs();
    for (int v = 0; v < (1 << M); v++) begin
      step(1);
      in_data = v[M-1:0];
    end
    step(1);
  endtask

  task automatic build_counter();
    img = '0;
    set_lit(0, M+0, 1); set_or(0, 0);                       // q0' = ~q0
    set_lit(1, M+1, 0); set_lit(1, M+0, 1); set_or(1, 1);   // q1' = q1^q0
    set_lit(2, M+1, 1); set_lit(2, M+0, 0); set_or(1, 2);
    set_lit(3, M+0, 0); set_or(2, 3);                       // out2 = q0, combinational
    img[SELB+0] = 1; img[SELB+1] = 1;
  endtask

  task automatic build_comb();
    img = '0;
    set_lit(0, 0, 0); set_lit(0, 1, 1);   // term0 = x0 & ~x1
    set_lit(1, 2, 0); set_lit(1, 3, 0);   // term1 = x2 & x3, shared
    set_or(0, 0); set_or(0, 1);
    set_or(1, 1);
    set_or(2, 0); img[POLB+2] = 1;        // out2 = ~term0
  endtask

  initial begin
    step(3);
    rst = 0;
    checking = 1;
    req = "R1";
    check("R1", out_data, '0);
    step(2);

    // R5: all OR links set, no literals
    req = "R5";
    img = '0;
    for (int o = 0; o < N; o++) for (int t = 0; t < P; t++) set_or(o, t);
    send_img(0, 1);
    sweep_inputs();
    check("R5", out_data, '0);

    // R4 R6 R7: combinational function with a shared term and an inverted output
    req = "R6";
    build_comb();
    send_img(0, 1);
    req = "R4";
    sweep_inputs();
    req = "R7";
    in_data = 4'b0001; step(1);
    check("R7", out_data, 3'b001);
    in_data = 4'b1100; step(1);
    check("R6", out_data, 3'b111);

    // R8 R9: counter built from feedback literals
    req = "R8";
    build_counter();
    send_img(0, 1);
    req = "R9";
    step(9);

    // R2 R3: load a new image with idle junk cycles, no commit yet
    req = "R3";
    build_comb();
    send_img(1, 0);
    req = "R2";
    step(4);
    // R10: commit while the counter runs, with a bit shifted on the same edge
    req = "R10";
    cfg_commit = 1; cfg_valid = 1; cfg_bit = 1;
    step(1);
    cfg_commit = 0; cfg_valid = 0; cfg_bit = 0;
    sweep_inputs();

    // R11: reset in the middle of counting
    req = "R8";
    build_counter();
    send_img(0, 1);
    step(3);
    req = "R11";
    rst = 1;
    step(1);
    rst = 0;
    check("R11", out_data, '0);
    step(3);
    check("R11", out_data, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run incomplete, actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule